// File: doc/BRIEF.md
# Battery Charge-Phase Sequencer

This block runs the charge cycle of a nickel-chemistry battery charger. A cycle starts when the block comes out of reset, or when the over-voltage flag falls back, which marks a battery that was just swapped in. The block first checks that the battery is fit to charge. It then runs fast charge, optionally a reduced-rate top-off phase, and finally an untimed maintenance trickle. Analog comparators, the converter and a voltage-slope detector sit outside the block. They hand it single-bit flags and a one-cycle termination pulse. A three-level mode input, already decoded, chooses the timing profile.

One counter serves as both the safety timer and the hold-off timer. It advances only on cycles where the prescaled `tick_en` is high, and `UNIT_TICKS` sets how many ticks make up 30 seconds. A phase code tells an external current modulator which pulse pattern to apply. A status LED enable is high during fast charge, and a flag reports the hold-off window during which slope terminations are ignored.

Top module: `charge_sequencer`

## Requirements
- R1: After reset, and on the cycle after `bat_hi_volt` falls from 1 to 0, the block spends exactly one cycle in a start state with phase code 0. It then enters fast charge if both flags are low. The phase codes are 0 = outputs released, 1 = fast, 2 = top-off, 3 = trickle.
- R2: If `bat_hi_volt` or `bat_hot` is high during the start cycle, the block goes straight to trickle. It stays there until the next new cycle.
- R3: Fast charge ends by timeout after a safety limit of ticks that depends on the mode. `mode_sel` 00 (low) gives 160 units, 01 (mid) gives 320, 10 (high) gives 80, and 11 acts as mid, where one unit is `UNIT_TICKS` ticks. Only cycles with `tick_en` high count toward the limit.
- R4: `holdoff_act` is high for the first 10, 20 or 5 units of fast charge in low, mid and high mode respectively. A slope pulse is ignored during that window. The first slope pulse after the window ends fast charge.
- R5: `bat_hi_volt` or `bat_hot` ends fast charge or top-off on the next cycle and moves the block to trickle. Hold-off does not delay this.
- R6: After a timeout or an accepted slope pulse, low and mid modes enter top-off and high mode enters trickle. The safety counter restarts at top-off entry, and top-off times out after the same limit as fast charge.
- R7: Slope pulses have no effect during top-off.
- R8: Trickle has no time limit. It lasts until a new cycle starts or low-power is requested.
- R9: Outside inhibit, `led_on` is high exactly when the block is in fast charge.
- R10: While `inhibit` is high, fast charge and top-off show phase code 3 and their timer stops. `led_on` keeps its value, even if a temperature or voltage termination occurs meanwhile. The suspended phase resumes when `inhibit` falls.
- R11: While `low_power` is high, the phase code is 0 and `led_on` is low. On the cycle after it clears, the block is in trickle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; a reset starts a new cycle |
| tick_en | input | 1 | Prescaled timebase enable, one cycle wide |
| mode_sel | input | 2 | Decoded mode: 00 low, 01 mid, 10 high, 11 as mid |
| bat_hi_volt | input | 1 | Cell voltage above the maximum-cell threshold |
| bat_hot | input | 1 | Temperature past the cutoff |
| slope_term | input | 1 | Voltage-slope termination pulse |
| inhibit | input | 1 | Suspend fast charge and top-off |
| low_power | input | 1 | Low-power request; releases the outputs |
| led_on | output | 1 | Status LED enable, high during fast charge |
| phase | output | 2 | Phase code for the current modulator |
| holdoff_act | output | 1 | Slope termination hold-off window active |

## Verification
The bench builds the block with `UNIT_TICKS` = 1. At that setting the safety limits are 160, 320 and 80 ticks and the hold-off windows are 10, 20 and 5 ticks. This makes it cheap to sweep all four mode codes against both the timeout path and a slope pulse held high from the first cycle. Each phase length is compared with the exact count derived from those numbers. With the same short windows, inhibit pauses, a tick that toggles every cycle, and terminations inside hold-off and inside top-off can each be timed exactly.

// File: rtl/chg_pkg.sv
// Shared types and timing constants for the charge sequencer.
// Assumes one time unit equals 30 seconds; all limits are in units.
package chg_pkg;

    typedef enum logic [2:0] {
        ST_START,
        ST_FAST,
        ST_TOP,
        ST_TRICKLE,
        ST_SLEEP
    } chg_state_t;

    localparam logic [1:0] PH_OFF     = 2'd0;
    localparam logic [1:0] PH_FAST    = 2'd1;
    localparam logic [1:0] PH_TOP     = 2'd2;
    localparam logic [1:0] PH_TRICKLE = 2'd3;

    localparam logic [1:0] MODE_LOW  = 2'd0;
    localparam logic [1:0] MODE_MID  = 2'd1;
    localparam logic [1:0] MODE_HIGH = 2'd2;

    localparam int SAFE_U_LOW  = 160;
    localparam int SAFE_U_MID  = 320;
    localparam int SAFE_U_HIGH = 80;
    localparam int HOLD_U_LOW  = 10;
    localparam int HOLD_U_MID  = 20;
    localparam int HOLD_U_HIGH = 5;

endpackage

// File: rtl/chg_mode_table.sv
// Maps the decoded mode to tick limits and the top-off enable.
// Assumes mode code 11 is treated like mid, the longest profile.
module chg_mode_table #(
    parameter int UNIT_TICKS = 300,
    parameter int CNT_W      = 17
) (
    input  logic [1:0]       mode_sel,
    output logic [CNT_W-1:0] safe_lim,
    output logic [CNT_W-1:0] hold_lim,
    output logic             topoff_en
);
    import chg_pkg::*;

    localparam logic [CNT_W-1:0] SAFE_LOW  = CNT_W'(SAFE_U_LOW  * UNIT_TICKS);
    localparam logic [CNT_W-1:0] SAFE_MID  = CNT_W'(SAFE_U_MID  * UNIT_TICKS);
    localparam logic [CNT_W-1:0] SAFE_HIGH = CNT_W'(SAFE_U_HIGH * UNIT_TICKS);
    localparam logic [CNT_W-1:0] HOLD_LOW  = CNT_W'(HOLD_U_LOW  * UNIT_TICKS);
    localparam logic [CNT_W-1:0] HOLD_MID  = CNT_W'(HOLD_U_MID  * UNIT_TICKS);
    localparam logic [CNT_W-1:0] HOLD_HIGH = CNT_W'(HOLD_U_HIGH * UNIT_TICKS);

    // Select the limits for the current mode.
    always_comb begin
        case (mode_sel)
            MODE_LOW: begin
                safe_lim  = SAFE_LOW;
                hold_lim  = HOLD_LOW;
                topoff_en = 1'b1;
            end
            MODE_HIGH: begin
                safe_lim  = SAFE_HIGH;
                hold_lim  = HOLD_HIGH;
                topoff_en = 1'b0;
            end
            default: begin
                safe_lim  = SAFE_MID;
                hold_lim  = HOLD_MID;
                topoff_en = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/chg_phase_timer.sv
// Shared safety and hold-off counter for the timed charge phases.
// Assumes hold_lim < safe_lim; clr has priority over adv.
module chg_phase_timer #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [CNT_W-1:0] safe_lim,
    input  logic [CNT_W-1:0] hold_lim,
    output logic             expire,
    output logic             in_holdoff
);
    logic [CNT_W-1:0] cnt;

    // Count elapsed ticks of the current phase, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (adv && cnt < safe_lim) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Expiry fires on the tick that completes the limit.
    assign expire     = adv && ((cnt + CNT_W'(1)) >= safe_lim);
    assign in_holdoff = cnt < hold_lim;

endmodule

// File: rtl/charge_sequencer.sv
// Charge-phase sequencer: start check, fast, top-off, trickle, sleep.
// Assumes all inputs are synchronous; tick_en is a one-cycle enable.
module charge_sequencer #(
    parameter int UNIT_TICKS = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [1:0] mode_sel,
    input  logic       bat_hi_volt,
    input  logic       bat_hot,
    input  logic       slope_term,
    input  logic       inhibit,
    input  logic       low_power,
    output logic       led_on,
    output logic [1:0] phase,
    output logic       holdoff_act
);
    import chg_pkg::*;

    localparam int MAX_TICKS = SAFE_U_MID * UNIT_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 2);

    chg_state_t       st, st_nxt;
    logic             hv_q, new_cycle, limit_bad, running, adv, clr;
    logic             expire, in_holdoff, topoff_en, led_q;
    logic [CNT_W-1:0] safe_lim, hold_lim;

    chg_mode_table #(.UNIT_TICKS(UNIT_TICKS), .CNT_W(CNT_W)) i_table (
        .mode_sel  (mode_sel),
        .safe_lim  (safe_lim),
        .hold_lim  (hold_lim),
        .topoff_en (topoff_en)
    );

    chg_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .adv        (adv),
        .safe_lim   (safe_lim),
        .hold_lim   (hold_lim),
        .expire     (expire),
        .in_holdoff (in_holdoff)
    );

    assign new_cycle = hv_q && !bat_hi_volt;
    assign limit_bad = bat_hi_volt || bat_hot;
    assign running   = (st == ST_FAST) || (st == ST_TOP);
    assign adv       = tick_en && running && !inhibit;
    assign clr       = (st_nxt == ST_FAST && st != ST_FAST) ||
                       (st_nxt == ST_TOP  && st != ST_TOP);

    // Next-state selection; low-power has priority, then a new cycle.
    always_comb begin
        st_nxt = st;
        if (low_power) begin
            st_nxt = ST_SLEEP;
        end else if (st == ST_SLEEP) begin
            st_nxt = ST_TRICKLE;
        end else if (new_cycle) begin
            st_nxt = ST_START;
        end else begin
            case (st)
                ST_START: st_nxt = limit_bad ? ST_TRICKLE : ST_FAST;
                ST_FAST: begin
                    if (limit_bad) begin
                        st_nxt = ST_TRICKLE;
                    end else if (expire || (slope_term && !inhibit && !in_holdoff)) begin
                        st_nxt = topoff_en ? ST_TOP : ST_TRICKLE;
                    end
                end
                ST_TOP: begin
                    if (limit_bad || expire) begin
                        st_nxt = ST_TRICKLE;
                    end
                end
                default: st_nxt = st;
            endcase
        end
    end

    // State and voltage-flag history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_START;
            hv_q <= 1'b0;
        end else begin
            st   <= st_nxt;
            hv_q <= bat_hi_volt;
        end
    end

    // LED follows fast charge, held while inhibited, cleared in low-power.
    always_ff @(posedge clk) begin
        if (!rst_n || low_power) begin
            led_q <= 1'b0;
        end else if (!inhibit) begin
            led_q <= (st_nxt == ST_FAST);
        end
    end

    // Phase code for the modulator; inhibit substitutes trickle.
    always_comb begin
        case (st)
            ST_FAST:    phase = inhibit ? PH_TRICKLE : PH_FAST;
            ST_TOP:     phase = inhibit ? PH_TRICKLE : PH_TOP;
            ST_TRICKLE: phase = PH_TRICKLE;
            default:    phase = PH_OFF;
        endcase
    end

    assign led_on      = led_q;
    assign holdoff_act = (st == ST_FAST) && in_holdoff;

endmodule

// File: rtl/chg_sequencer_chk.sv
// Port-level temporal checks for charge_sequencer, attached by bind.
// Assumes inputs are zero while reset is asserted.
module chg_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       inhibit,
    input logic       low_power,
    input logic       bat_hi_volt,
    input logic       bat_hot,
    input logic       led_on,
    input logic [1:0] phase,
    input logic       holdoff_act
);
    logic inh_q, lp_q, led_prev;

    // One-cycle history of inputs and LED used by the properties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inh_q    <= 1'b0;
            lp_q     <= 1'b0;
            led_prev <= 1'b0;
        end else begin
            inh_q    <= inhibit;
            lp_q     <= low_power;
            led_prev <= led_on;
        end
    end

    p_led_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!inhibit && !inh_q) |-> (led_on == (phase == 2'd1)));

    p_led_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_q && !lp_q) |-> (led_on == led_prev));

    p_sleep_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lp_q |-> (!led_on && phase == 2'd0));

    p_sleep_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_q && !low_power) |=> (phase == 2'd3));

    p_holdoff_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (holdoff_act && !inhibit && !bat_hi_volt && !bat_hot && !low_power)
        |=> (phase == 2'd1 || inhibit));

    p_limit_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == 2'd1 || phase == 2'd2) && (bat_hi_volt || bat_hot) && !low_power)
        |=> (phase == 2'd3));

endmodule

bind charge_sequencer chg_sequencer_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .inhibit     (inhibit),
    .low_power   (low_power),
    .bat_hi_volt (bat_hi_volt),
    .bat_hot     (bat_hot),
    .led_on      (led_on),
    .phase       (phase),
    .holdoff_act (holdoff_act)
);

// File: tb/test_charge_sequencer.sv
module test_charge_sequencer;

    logic       clk = 1'b0;
    logic       rst_n, tick_en, bat_hi_volt, bat_hot, slope_term, inhibit, low_power;
    logic [1:0] mode_sel;
    logic       led_on, holdoff_act;
    logic [1:0] phase;

    int n_checks = 0;
    int n_err    = 0;

    always #2 clk = ~clk;

    charge_sequencer #(.UNIT_TICKS(1)) i_charge_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .mode_sel    (mode_sel),
        .bat_hi_volt (bat_hi_volt),
        .bat_hot     (bat_hot),
        .slope_term  (slope_term),
        .inhibit     (inhibit),
        .low_power   (low_power),
        .led_on      (led_on),
        .phase       (phase),
        .holdoff_act (holdoff_act)
    );

    function automatic int safe_of(input int m);
        return (m == 2) ? 80 : (m == 0) ? 160 : 320;
    endfunction

    function automatic int hold_of(input int m);
        return (m == 2) ? 5 : (m == 0) ? 10 : 20;
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pulse the over-voltage flag to start a new cycle; ends on the first fast sample.
    task automatic new_cycle();
        bat_hi_volt = 1'b1;
        @(negedge clk);
        bat_hi_volt = 1'b0;
        @(negedge clk);
        check_eq("R1 start phase", int'(phase), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int nf, nh, nt, bad, nk;
        rst_n = 1'b0; tick_en = 1'b1; mode_sel = 2'd0; bat_hi_volt = 1'b0;
        bat_hot = 1'b0; slope_term = 1'b0; inhibit = 1'b0; low_power = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R1 reset phase", int'(phase), 0);
        check_eq("R1 reset led", int'(led_on), 0);
        check_eq("R4 reset holdoff", int'(holdoff_act), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 power-up fast", int'(phase), 1);
        check_eq("R9 power-up led", int'(led_on), 1);

        // R3 R4 R6 R7 R8 R9: every mode, timeout path and held slope path
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                mode_sel = 2'(m);
                slope_term = 1'b0;
                new_cycle();
                slope_term = (s == 1);
                nf = 0; nh = 0; bad = 0;
                while (phase == 2'd1 && nf < 1000) begin
                    nf++;
                    if (holdoff_act) nh++;
                    if (!led_on) bad++;
                    @(negedge clk);
                end
                check_eq((s == 1) ? "R4 slope after holdoff" : "R3 fast timeout",
                         nf, (s == 1) ? hold_of(m) + 1 : safe_of(m));
                check_eq("R4 holdoff length", nh, hold_of(m));
                check_eq("R9 led during fast", bad, 0);
                check_eq("R6 phase after fast", int'(phase), (m == 2) ? 3 : 2);
                if (m != 2) begin
                    nt = 0; bad = 0;
                    while (phase == 2'd2 && nt < 1000) begin
                        nt++;
                        if (led_on) bad++;
                        @(negedge clk);
                    end
                    check_eq("R7 top-off full length with slope", nt, safe_of(m));
                    check_eq("R9 led off in top-off", bad, 0);
                end
                slope_term = 1'b0;
                repeat (400) @(negedge clk);
                check_eq("R8 trickle untimed", int'(phase), 3);
                check_eq("R9 led off in trickle", int'(led_on), 0);
            end
        end

        // R3: only ticked cycles count
        mode_sel = 2'd2;
        new_cycle();
        nk = 0;
        while (phase == 2'd1 && nk < 1000) begin
            tick_en = ~tick_en;
            if (tick_en) nk++;
            @(negedge clk);
        end
        tick_en = 1'b1;
        check_eq("R3 ticks counted", nk, 80);

        // R10: inhibit pause keeps total fast time and holds the LED
        new_cycle();
        nf = 0; bad = 0;
        for (int k = 0; k < 400; k++) begin
            if (k > 11 && phase != 2'd1) break;
            if (phase == 2'd1) nf++;
            if (k >= 4 && k <= 10 && (phase != 2'd3 || !led_on)) bad++;
            if (k == 3) inhibit = 1'b1;
            if (k == 10) inhibit = 1'b0;
            @(negedge clk);
        end
        check_eq("R10 inhibit shows trickle and holds led", bad, 0);
        check_eq("R10 fast resumes and totals limit", nf, 80);

        // R10: LED frozen across a termination during inhibit
        new_cycle();
        inhibit = 1'b1;
        @(negedge clk);
        bat_hot = 1'b1;
        @(negedge clk);
        bat_hot = 1'b0;
        @(negedge clk);
        check_eq("R10 led frozen", int'(led_on), 1);
        inhibit = 1'b0;
        @(negedge clk);
        check_eq("R10 led released after inhibit", int'(led_on), 0);
        check_eq("R5 hot ended fast under inhibit", int'(phase), 3);

        // R5: over-voltage inside hold-off, then replacement restart
        mode_sel = 2'd0;
        new_cycle();
        check_eq("R4 in holdoff", int'(holdoff_act), 1);
        bat_hi_volt = 1'b1;
        @(negedge clk);
        check_eq("R5 over-voltage ends fast", int'(phase), 3);
        bat_hi_volt = 1'b0;
        @(negedge clk);
        check_eq("R1 replacement start", int'(phase), 0);
        @(negedge clk);
        check_eq("R1 replacement fast", int'(phase), 1);
        bat_hot = 1'b1;
        @(negedge clk);
        check_eq("R5 hot ends fast", int'(phase), 3);
        bat_hot = 1'b0;
        repeat (5) @(negedge clk);
        check_eq("R8 stays in trickle", int'(phase), 3);

        // R5: temperature ends top-off
        mode_sel = 2'd1;
        new_cycle();
        slope_term = 1'b1;
        while (phase == 2'd1) @(negedge clk);
        slope_term = 1'b0;
        check_eq("R6 top-off entered", int'(phase), 2);
        @(negedge clk);
        bat_hot = 1'b1;
        @(negedge clk);
        check_eq("R5 hot ends top-off", int'(phase), 3);
        bat_hot = 1'b0;

        // R2: start blocked by temperature
        bat_hot = 1'b1;
        new_cycle();
        check_eq("R2 hot start goes trickle", int'(phase), 3);
        bat_hot = 1'b0;
        repeat (5) @(negedge clk);
        check_eq("R2 stays trickle", int'(phase), 3);

        // R2: power-up with over-voltage, then release starts a cycle
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        bat_hi_volt = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R2 power-up over-voltage trickle", int'(phase), 3);
        check_eq("R9 led off", int'(led_on), 0);
        bat_hi_volt = 1'b0;
        @(negedge clk);
        check_eq("R1 start after release", int'(phase), 0);
        @(negedge clk);
        check_eq("R1 fast after release", int'(phase), 1);

        // R11: low-power releases outputs, exit to trickle
        low_power = 1'b1;
        @(negedge clk);
        check_eq("R11 phase released", int'(phase), 0);
        check_eq("R11 led released", int'(led_on), 0);
        repeat (3) @(negedge clk);
        low_power = 1'b0;
        @(negedge clk);
        check_eq("R11 exit to trickle", int'(phase), 3);
        check_eq("R11 led stays off", int'(led_on), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule